// File: doc/BRIEF.md
# Debug Wait-In-Reset Controller

This block lives inside a debug probe and owns the target processor's test reset and its two emulation pins across power cycles of the target. It filters an asynchronous presence-detect input (high means the cable is attached and the target has power). When that input reports that power has gone, the block forces a fixed hold pattern onto the pins. A processor that supports a wait-in-reset mode then comes up held in reset and stays there until the host starts a debug session.

A single-cycle start pulse from the host side ends the hold. Test reset goes high, EMU1 is let go, and a release timer starts. EMU0 keeps being pulled low until the timer expires, and is then left at high impedance. The timer limit comes from the clock frequency and the release time, and always falls within the 20 ms bound. A link indicator is lit whenever a powered target is seen. A new power loss in any state sends the block back to its idle, no-target state.

Top module: `tgt_hold_ctrl`

## Requirements
- R1: Once the filtered presence-detect is low, from any state, the block enters the no-target state: `emu0_pull_low`=1 (EMU0 driven to 0), `trst_n`=0.
- R2: In the no-target and hold states, the pins show the hold pattern: `trst_n`=0, `emu0_pull_low`=1, `emu1_drive_high`=1 (EMU1 driven to 1). `link_led` is 0 in no-target and 1 in hold.
- R3: While the target is powered and held, `trst_n` stays 0 until `session_start` is seen. A `session_start` pulse with no target present has no effect.
- R4: A `session_start` high on a clock edge in the hold state sets `trst_n`=1 and `emu1_drive_high`=0 at that edge, with `emu0_pull_low` still 1.
- R5: EMU0 is released (`emu0_pull_low`=0) exactly RELEASE_CYCLES = CLK_KHZ*RELEASE_MS clock cycles after `trst_n` rises, and never later.
- R6: `link_led` is 1 exactly when the block is not in the no-target state.
- R7: `pd_raw` passes through a two-stage synchronizer and a debounce filter. A level change shorter than DEBOUNCE_CYCLES cycles has no effect on any output.
- R8: During and right after reset, the outputs take the no-target pattern: `trst_n`=0, `emu0_pull_low`=1, `emu1_drive_high`=1, `link_led`=0.
- R9: `session_start` has no effect during the release wait or in the active state.
- R10: Whenever `trst_n` is 1, EMU1 is released (`emu1_drive_high`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_raw | input | 1 | Asynchronous presence-detect, 1 = powered target attached |
| session_start | input | 1 | Single-cycle host pulse that ends the hold |
| trst_n | output | 1 | Active-low test reset to the target |
| emu0_pull_low | output | 1 | 1 = drive EMU0 to 0, 0 = EMU0 high impedance |
| emu1_drive_high | output | 1 | 1 = drive EMU1 to 1, 0 = EMU1 high impedance |
| link_led | output | 1 | Connection indicator, 1 = lit |

## Verification
On every cycle, the assertions check the pin relations: EMU0 is held low whenever test reset is asserted, EMU1 is let go whenever test reset is high, and test reset rises only after a start pulse. They also check that the release counter never goes past its limit, that a lost presence pulls the pins back, and that the debounced level flips only after a full filter window. Only the bench scenarios can show the exact release interval in cycles, that short presence glitches leave the outputs unchanged, that start pulses outside the hold state are ignored, and that the right pattern is reached after random sequences of power cycles and session starts.

// File: rtl/tgt_hold_pkg.sv
package tgt_hold_pkg;

    typedef enum logic [1:0] {
        ST_NO_TARGET    = 2'd0,
        ST_HOLD_RESET   = 2'd1,
        ST_RELEASE_WAIT = 2'd2,
        ST_ACTIVE       = 2'd3
    } hold_state_e;

    typedef struct packed {
        logic trst_n;
        logic emu0_low;
        logic emu1_high;
        logic led;
    } pin_drive_t;

    function automatic pin_drive_t pins_for(hold_state_e st);
        pin_drive_t p;
        p.trst_n    = (st == ST_RELEASE_WAIT) || (st == ST_ACTIVE);
        p.emu0_low  = (st != ST_ACTIVE);
        p.emu1_high = (st == ST_NO_TARGET) || (st == ST_HOLD_RESET);
        p.led       = (st != ST_NO_TARGET);
        return p;
    endfunction

endpackage

// File: rtl/pd_filter.sv
module pd_filter #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_async,
    output logic pd_ok
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam int MSB   = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   stable;
        logic [CNT_W-1:0]       cnt;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d      = filt_q;
        filt_d.sync = {filt_q.sync[SYNC_STAGES-2:0], pd_async};
        if (filt_q.sync[MSB] == filt_q.stable) begin
            filt_d.cnt = '0;
        end else if (filt_q.cnt == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
            filt_d.stable = filt_q.sync[MSB];
            filt_d.cnt    = '0;
        end else begin
            filt_d.cnt = filt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= '0;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign pd_ok = filt_q.stable;

    AST_FLIP_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_ok != $past(pd_ok)) |-> ($past(filt_q.cnt) == CNT_W'(DEBOUNCE_CYCLES - 1))); // R7

endmodule

// File: rtl/release_timer.sv
module release_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        if (!run || done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CNT_W'(LIMIT))); // R5

endmodule

// File: rtl/tgt_hold_ctrl.sv
module tgt_hold_ctrl
    import tgt_hold_pkg::*;
#(
    parameter int CLK_KHZ         = 125000,
    parameter int RELEASE_MS      = 20,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_raw,
    input  logic session_start,
    output logic trst_n,
    output logic emu0_pull_low,
    output logic emu1_drive_high,
    output logic link_led
);
    localparam int RELEASE_CYCLES = CLK_KHZ * RELEASE_MS;

    typedef struct packed {
        hold_state_e state;
        pin_drive_t  pins;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  pd_ok;
    logic  rel_run;
    logic  rel_done;

    pd_filter #(
        .SYNC_STAGES     (2),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_pd_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_async (pd_raw),
        .pd_ok    (pd_ok)
    );

    assign rel_run = (ctrl_q.state == ST_RELEASE_WAIT);

    release_timer #(
        .LIMIT (RELEASE_CYCLES)
    ) u_release_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rel_run),
        .done  (rel_done)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (!pd_ok) begin
            ctrl_d.state = ST_NO_TARGET;
        end else begin
            unique case (ctrl_q.state)
                ST_NO_TARGET:    ctrl_d.state = ST_HOLD_RESET;
                ST_HOLD_RESET:   if (session_start) ctrl_d.state = ST_RELEASE_WAIT;
                ST_RELEASE_WAIT: if (rel_done) ctrl_d.state = ST_ACTIVE;
                ST_ACTIVE:       ctrl_d.state = ST_ACTIVE;
                default:         ctrl_d.state = ST_NO_TARGET;
            endcase
        end
        ctrl_d.pins = pins_for(ctrl_d.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_NO_TARGET;
            ctrl_q.pins  <= pins_for(ST_NO_TARGET);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign trst_n          = ctrl_q.pins.trst_n;
    assign emu0_pull_low   = ctrl_q.pins.emu0_low;
    assign emu1_drive_high = ctrl_q.pins.emu1_high;
    assign link_led        = ctrl_q.pins.led;

    AST_LOSS_FORCES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ok |=> (emu0_pull_low && !trst_n && !link_led)); // R1
    AST_HOLD_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !trst_n |-> (emu0_pull_low && emu1_drive_high)); // R2
    AST_HOLD_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!trst_n && !session_start) |=> !trst_n); // R3
    AST_TRST_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trst_n) |-> $past(session_start)); // R4
    AST_LED_NEEDS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        link_led |-> $past(pd_ok)); // R6
    AST_EMU1_LET_GO: assert property (@(posedge clk) disable iff (!rst_n)
        trst_n |-> !emu1_drive_high); // R10

endmodule

// File: tb/tgt_hold_ctrl_test.sv
module tgt_hold_ctrl_test;
    localparam int CLK_KHZ  = 50;
    localparam int REL_MS   = 20;
    localparam int DEB      = 8;
    localparam int LIMIT    = CLK_KHZ * REL_MS;
    localparam int SETTLE   = DEB + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_raw = 1'b0;
    logic session_start = 1'b0;
    logic trst_n, emu0_pull_low, emu1_drive_high, link_led;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_state = 0;

    always #4 clk = ~clk;

    tgt_hold_ctrl #(
        .CLK_KHZ         (CLK_KHZ),
        .RELEASE_MS      (REL_MS),
        .DEBOUNCE_CYCLES (DEB)
    ) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pd_raw          (pd_raw),
        .session_start   (session_start),
        .trst_n          (trst_n),
        .emu0_pull_low   (emu0_pull_low),
        .emu1_drive_high (emu1_drive_high),
        .link_led        (link_led)
    );

    // {trst_n, emu0_pull_low, emu1_drive_high, link_led}
    function automatic logic [3:0] exp_pins(int st);
        case (st)
            0:       return 4'b0110;
            1:       return 4'b0111;
            2:       return 4'b1101;
            default: return 4'b1001;
        endcase
    endfunction

    function automatic logic [3:0] act_pins();
        return {trst_n, emu0_pull_low, emu1_drive_high, link_led};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        session_start = 1'b1;
        step(1);
        session_start = 1'b0;
    endtask

    // From hold: start, measure release length, optional extra start mid-wait
    task automatic measure_release(bit extra);
        int n = 0;
        pulse_start();
        chk("R4", act_pins(), exp_pins(2));
        while (trst_n && emu0_pull_low && n < LIMIT + 20) begin
            n++;
            if (extra && n == LIMIT / 2) session_start = 1'b1;
            step(1);
            session_start = 1'b0;
        end
        chk_int(extra ? "R9" : "R5", n, LIMIT);
        chk(extra ? "R9" : "R5", act_pins(), exp_pins(3));
        m_state = 3;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_0042);
        step(4);
        chk("R8", act_pins(), exp_pins(0));
        rst_n = 1'b1;
        step(2);
        chk("R8", act_pins(), exp_pins(0));

        pulse_start();
        step(2);
        chk("R3", act_pins(), exp_pins(0));

        pd_raw = 1'b1;
        step(SETTLE);
        m_state = 1;
        chk("R2", act_pins(), exp_pins(1));
        chk("R6", {3'b0, link_led}, 4'b0001);

        pd_raw = 1'b0;
        step(3);
        pd_raw = 1'b1;
        step(SETTLE);
        chk("R7", act_pins(), exp_pins(1));

        step(50);
        chk("R3", act_pins(), exp_pins(1));

        measure_release(1'b0);
        chk("R10", {3'b0, emu1_drive_high}, 4'b0000);

        pulse_start();
        step(2);
        chk("R9", act_pins(), exp_pins(3));

        pd_raw = 1'b0;
        step(SETTLE);
        m_state = 0;
        chk("R1", act_pins(), exp_pins(0));
        chk("R6", {3'b0, link_led}, 4'b0000);

        pd_raw = 1'b1;
        step(3);
        pd_raw = 1'b0;
        step(SETTLE);
        chk("R7", act_pins(), exp_pins(0));

        pd_raw = 1'b1;
        step(SETTLE);
        measure_release(1'b1);

        pd_raw = 1'b0;
        step(SETTLE);
        pd_raw = 1'b1;
        step(SETTLE);
        pulse_start();
        step(20);
        chk("R4", act_pins(), exp_pins(2));
        pd_raw = 1'b0;
        step(SETTLE);
        m_state = 0;
        chk("R1", act_pins(), exp_pins(0));

        for (int i = 0; i < 30; i++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: begin
                    pd_raw = ~pd_raw;
                    step(SETTLE);
                    m_state = pd_raw ? 1 : 0;
                    chk("R1", act_pins(), exp_pins(m_state));
                end
                1: begin
                    pulse_start();
                    step(1);
                    if (m_state == 1) begin
                        chk("R4", act_pins(), exp_pins(2));
                        step(LIMIT);
                        m_state = 3;
                        chk("R5", act_pins(), exp_pins(3));
                    end else begin
                        chk("R9", act_pins(), exp_pins(m_state));
                    end
                end
                2: begin
                    pd_raw = ~pd_raw;
                    step(int'($urandom_range(1, 3)));
                    pd_raw = ~pd_raw;
                    step(SETTLE);
                    chk("R7", act_pins(), exp_pins(m_state));
                end
                default: begin
                    step(int'($urandom_range(1, 40)));
                    chk("R3", act_pins(), exp_pins(m_state));
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule